// File: doc/BRIEF.md
# Free-Running Tick Counter with One Compare Interrupt

This block is a small peripheral timer on a plain 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Inside, a 64-bit tick counter starts at zero and counts one step per clock. Software sees the counter as two live 32-bit words. It has no latch. When software reads the low word and then the high word, a carry can land between the two reads, so software must read the high word again to detect this.

One compare channel watches the low 32 bits of the counter. Software writes a target tick into the compare register and sets an enable bit. When the low word equals the target and the channel is enabled, a sticky match flag sets on the next clock. The interrupt output is a level that follows the flag. Software acknowledges the interrupt by writing one to the flag bit. If a new match arrives in the same cycle as that clearing write, the match wins.

The register bus is a control path, not a data stream. It therefore has no valid/ready handshake: every write strobe is taken at the clock edge it is seen.

Top module: `systick_cmp_timer`

## Requirements
- R1: While reset is asserted, the counter, compare register, enable bit and match flag are all zero, and `tmr_irq` is low.
- R2: The counter rises by exactly one on every clock after reset. Offset 0x4 reads counter bits [31:0] and offset 0x8 reads bits [63:32]. Both are read live, with no snapshot taken.
- R3: Writes to offsets 0x4 and 0x8 have no effect on the counter.
- R4: Offset 0xC is the compare register. A write loads all 32 bits, and a read returns the stored value.
- R5: Offset 0x0 is the control/status word. Bit 4 is the compare enable (read/write) and bit 0 is the match flag. All other bits read as zero.
- R6: With the enable set, the flag sets on the clock edge after the one at which the low counter word equals the compare value. `tmr_irq` equals the flag. A compare value loaded 6 or more ticks ahead of the low word is reached and matched.
- R7: With the enable clear, an equal low word and compare value never set the flag.
- R8: A write to offset 0x0 with bit 0 = 1 clears the flag. With bit 0 = 0 it leaves the flag as it was. Changing the enable bit never alters the flag.
- R9: When a flag-clearing write and a match fall in the same cycle, the flag stays set.
- R10: Reads of any offset other than 0x0, 0x4, 0x8 and 0xC return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 4 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tmr_irq | output | 1 | Level interrupt, equal to the match flag |

## Verification
The compare function is tested in four ways:
- A target placed several ticks ahead with the channel enabled. The interrupt must rise exactly when the low word reads one past the target, which catches an off-by-one match or a registered stage that is missing or extra.
- The same target with the channel disabled, which separates the enable gate from the equality test.
- A clearing write timed to land on the matching cycle, which shows the priority of set over clear.
- Writes of 0 to the flag and toggles of the enable while the flag is set, which separate write-one-to-clear from a plain register write.

Counter words are sampled a known number of cycles apart, both with and without intervening writes to their offsets.

// File: rtl/systmr_pkg.sv
package systmr_pkg;
  localparam int WORD_W = 32;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_LO   = 4'h4;
  localparam logic [3:0] OFS_HI   = 4'h8;
  localparam logic [3:0] OFS_CMP  = 4'hC;

  // control word bit positions (software depends on these)
  localparam int FLAG_BIT = 0;
  localparam int EN_BIT   = 4;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_LO,
    SEL_HI,
    SEL_CMP,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/systmr_decode.sv
module systmr_decode
  import systmr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    unique case (addr)
      ADDR_W'(OFS_CTRL): sel = SEL_CTRL;
      ADDR_W'(OFS_LO):   sel = SEL_LO;
      ADDR_W'(OFS_HI):   sel = SEL_HI;
      ADDR_W'(OFS_CMP):  sel = SEL_CMP;
      default:           sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/systmr_counter.sv
module systmr_counter #(
  parameter int WORD_W = 32,
  parameter int N_WORDS = 2,
  localparam int CNT_W = WORD_W * N_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  // Segmented counter: each word steps when every lower word is all ones.
  logic [N_WORDS:0] carry;
  assign carry[0] = 1'b1;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    assign carry[w+1] = carry[w] & (&word_q);
    always_ff @(posedge clk) begin
      if (!rst_n)        word_q <= '0;
      else if (carry[w]) word_q <= word_q + WORD_W'(1);
    end
    assign cnt[w*WORD_W +: WORD_W] = word_q;
  end
endmodule

// File: rtl/systmr_compare.sv
module systmr_compare #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cmp,
  input  logic [WORD_W-1:0] wdata,
  input  logic              clr_req,
  input  logic              en_req,
  input  logic [WORD_W-1:0] cnt_lo,
  output logic [WORD_W-1:0] cmp_q,
  output logic              en_q,
  output logic              flag_q
);
  logic hit;
  assign hit = en_q && (cnt_lo == cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_cmp)  cmp_q <= wdata;
      if (wr_ctrl) en_q  <= en_req;
      // a match outranks a same-cycle clear
      if (hit)                     flag_q <= 1'b1;
      else if (wr_ctrl && clr_req) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/systick_cmp_timer.sv
module systick_cmp_timer
  import systmr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = WORD_W,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tmr_irq
);
  reg_sel_e          sel;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] cmp_q;
  logic              en_q;
  logic              flag_q;
  logic [DATA_W-1:0] ctrl_word;

  systmr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr (reg_addr),
    .sel  (sel)
  );

  systmr_counter #(.WORD_W(DATA_W), .N_WORDS(2)) cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt)
  );

  systmr_compare #(.WORD_W(DATA_W)) cmp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ctrl (reg_wr && (sel == SEL_CTRL)),
    .wr_cmp  (reg_wr && (sel == SEL_CMP)),
    .wdata   (reg_wdata),
    .clr_req (reg_wdata[FLAG_BIT]),
    .en_req  (reg_wdata[EN_BIT]),
    .cnt_lo  (cnt[DATA_W-1:0]),
    .cmp_q   (cmp_q),
    .en_q    (en_q),
    .flag_q  (flag_q)
  );

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[FLAG_BIT] = flag_q;
    ctrl_word[EN_BIT]   = en_q;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: reg_rdata = ctrl_word;
      SEL_LO:   reg_rdata = cnt[DATA_W-1:0];
      SEL_HI:   reg_rdata = cnt[CNT_W-1:DATA_W];
      SEL_CMP:  reg_rdata = cmp_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign tmr_irq = flag_q;
endmodule

// File: rtl/systick_cmp_timer_chk.sv
module systick_cmp_timer_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              tmr_irq,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] cmp_q,
  input logic              en_q
);
  logic ctrl_wr, ctrl_clr, eq_now;
  assign ctrl_wr  = reg_wr && (reg_addr == ADDR_W'(0));
  assign ctrl_clr = ctrl_wr && reg_wdata[0];
  assign eq_now   = cnt[DATA_W-1:0] == cmp_q;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cnt == $past(cnt) + CNT_W'(1));

  p_set_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && eq_now) |=> tmr_irq);

  p_irq_rise_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_irq) |-> $past(en_q && eq_now));

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !tmr_irq) |=> !tmr_irq);

  p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_clr && !(en_q && eq_now)) |=> !tmr_irq);

  p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_irq && !ctrl_clr) |=> tmr_irq);

  p_match_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_clr && en_q && eq_now) |=> tmr_irq);
endmodule

bind systick_cmp_timer systick_cmp_timer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .tmr_irq   (tmr_irq),
  .cnt       (cnt),
  .cmp_q     (cmp_q),
  .en_q      (en_q)
);

// File: tb/systick_cmp_timer_tb_top.sv
module systick_cmp_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tmr_irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  systick_cmp_timer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tmr_irq   (tmr_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    bus_read(4'h0, v); check("R1 ctrl", v, 32'h0);
    bus_read(4'h4, v); check("R1 lo", v, 32'h0);
    bus_read(4'h8, v); check("R1 hi", v, 32'h0);
    bus_read(4'hC, v); check("R1 cmp", v, 32'h0);
    check("R1 irq", {31'b0, tmr_irq}, 32'h0);
  endtask

  task automatic t_count_step();
    logic [31:0] a, b;
    bus_read(4'h4, a);
    repeat (7) @(negedge clk);
    bus_read(4'h4, b);
    check("R2 lo step", b - a, 32'd7);
    bus_read(4'h8, b);
    check("R2 hi live", b, 32'h0);
  endtask

  task automatic t_count_ignore();
    logic [31:0] a, b;
    bus_read(4'h4, a);
    bus_write(4'h4, 32'h0);
    bus_read(4'h4, b);
    check("R3 lo write ignored", b, a + 32'd1);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_read(4'h8, b);
    check("R3 hi write ignored", b, 32'h0);
  endtask

  task automatic t_match();
    logic [31:0] a, tgt, v;
    bit seen = 0;
    bus_read(4'h4, a);
    tgt = a + 32'd8;
    bus_write(4'hC, tgt);
    bus_read(4'hC, v); check("R4 cmp readback", v, tgt);
    bus_write(4'h0, 32'h10);
    bus_read(4'h0, v); check("R5 enable readback", v, 32'h10);
    check("R6 irq low before match", {31'b0, tmr_irq}, 32'h0);
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      bus_read(4'h4, v);
      if (tmr_irq) begin
        seen = 1;
        check("R6 irq rises one tick after equality", v, tgt + 32'd1);
      end
    end
    check("R6 match seen", {31'b0, seen}, 32'h1);
    bus_read(4'h0, v); check("R5 ctrl flag+enable", v, 32'h11);
  endtask

  task automatic t_clear_rules();
    logic [31:0] v;
    bus_write(4'h0, 32'h10);
    check("R8 write 0 keeps flag", {31'b0, tmr_irq}, 32'h1);
    bus_write(4'h0, 32'h00);
    bus_read(4'h0, v); check("R8 disable keeps flag", v, 32'h01);
    bus_write(4'h0, 32'h01);
    bus_read(4'h0, v); check("R8 write 1 clears", v, 32'h00);
    check("R8 irq low after clear", {31'b0, tmr_irq}, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] a;
    bus_read(4'h4, a);
    bus_write(4'hC, a + 32'd4);
    repeat (10) @(negedge clk);
    check("R7 no match while disabled", {31'b0, tmr_irq}, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] a, tgt, v;
    bit hit = 0;
    bus_read(4'h4, a);
    tgt = a + 32'd6;
    bus_write(4'hC, tgt);
    bus_write(4'h0, 32'h10);
    for (int i = 0; i < 12 && !hit; i++) begin
      bus_read(4'h4, v);
      if (v == tgt) hit = 1;
      else @(negedge clk);
    end
    check("R9 reached equality", {31'b0, hit}, 32'h1);
    bus_write(4'h0, 32'h11);
    check("R9 match beats clear", {31'b0, tmr_irq}, 32'h1);
    bus_write(4'h0, 32'h01);
    check("R8 clear after collision", {31'b0, tmr_irq}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    bus_read(4'h2, v); check("R10 offset 0x2", v, 32'h0);
    bus_read(4'h6, v); check("R10 offset 0x6", v, 32'h0);
    bus_read(4'hF, v); check("R10 offset 0xF", v, 32'h0);
  endtask

  task automatic t_reset_again();
    logic [31:0] a;
    bus_read(4'h4, a);
    bus_write(4'hC, a + 32'd6);
    bus_write(4'h0, 32'h10);
    repeat (8) @(negedge clk);
    check("R6 flag set before reset", {31'b0, tmr_irq}, 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_count_step();
    t_count_ignore();
    t_match();
    t_clear_rules();
    t_disabled();
    t_collision();
    t_unmapped();
    t_reset_again();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule